// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block forms byte addresses from a segment base and a 16-bit offset, the way a real-mode segmented processor does. It holds four 16-bit segment registers: extra, code, stack and data. A simple write port loads them. On a request, a 2-bit selector picks one register. Its value is shifted left by a parameterised amount (4 by default, so one segment step is 16 bytes) and added to the offset. The sum is one bit wider than the 20-bit base range, so the carry out of the base range is kept as address line 20.

A programmable gate decides what happens to that top bit. When the gate is open, the bit passes through, and addresses just above 1 MiB can be reached. When the gate is closed, the bit is forced to zero, so addresses past FFFFFh wrap to the bottom of memory, as on a 20-bit machine. An overflow flag reports the raw carry whatever the gate setting. The result is registered and is marked by a valid strobe one cycle after the request.

Top module: `seg_addr_gen`

## Requirements
- R1: With the gate open, the address output equals (segment << 4) + offset as a 21-bit unsigned sum, byte-granular, with bit 20 carrying the sum's carry.
- R2: With the gate closed, address bit 20 is 0 and bits 19:0 equal the low 20 bits of the sum, so an address past FFFFFh wraps to 00000h upward.
- R3: After reset the gate is closed.
- R4: The overflow output equals bit 20 of the unmasked sum for the same request, whether the gate is open or closed.
- R5: The select encoding is 00 = extra, 01 = code, 10 = stack, 11 = data. The four registers hold independent values.
- R6: When the write enable is high, the selected register takes the write data at the next clock edge. A request in that same cycle uses the old value. When the write enable is low, the write data has no effect.
- R7: The address and overflow outputs are registered. Valid is high in the cycle after a request and low in the cycle after a cycle without one. The address and overflow hold their values while no request arrives.
- R8: During and after reset, all segment registers are zero, and valid, address and overflow are 0.
- R9: A gate write takes effect for requests in later cycles. A request in the same cycle as the gate write uses the previous gate setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_we | input | 1 | Segment register write enable |
| seg_wsel | input | 2 | Register written (R5 encoding) |
| seg_wdata | input | 16 | Segment value to write |
| gate_we | input | 1 | Gate control write enable |
| gate_open_in | input | 1 | New gate setting: 1 passes bit 20, 0 forces it to zero |
| req | input | 1 | Address request strobe |
| req_sel | input | 2 | Segment register used for the request |
| req_off | input | 16 | Byte offset within the segment |
| phys_addr | output | 21 | Registered physical address |
| addr_valid | output | 1 | phys_addr holds a new result |
| carry_ovf | output | 1 | Unmasked sum reached bit 20 |

## Verification
Assertions check several properties on every cycle. Valid follows the request by one cycle and the outputs hold when there is no request. Address bit 20 is never set when the gate was closed at request time. A set bit 20 always comes with the overflow flag. A register write lands in the addressed register. Only the bench's scenarios can show the following: the arithmetic values themselves, including the wrap of FFFF:0010 to zero and of FFFF:FFFF to 0FFEFh; the closed gate after reset; the independence of the four registers; and the old-value behaviour when a write or a gate change shares a cycle with a request.

// File: rtl/seg_addr_pkg.sv
// Package: shared widths and the segment register select encoding.
// Assumes: the shifted segment is at least as wide as the offset.
package seg_addr_pkg;
    localparam int SEG_W_DEF   = 16;
    localparam int OFF_W_DEF   = 16;
    localparam int SHIFT_DEF   = 4;

    // Select encoding used by both the write port and the request port.
    typedef enum logic [1:0] {
        SEG_EXTRA = 2'b00,
        SEG_CODE  = 2'b01,
        SEG_STACK = 2'b10,
        SEG_DATA  = 2'b11
    } seg_sel_e;

    localparam int NUM_SEGS = 4;
endpackage

// File: rtl/seg_regfile.sv
// Module: seg_regfile
// Four segment registers with one write port and one combinational read port.
// Assumes: a read in the same cycle as a write returns the old value.
module seg_regfile
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = SEG_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       wsel,
    input  logic [SEG_W-1:0] wdata,
    input  logic [1:0]       rsel,
    output logic [SEG_W-1:0] rdata
);
    logic [SEG_W-1:0] seg_q [NUM_SEGS];

    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
        // Load one register when it is addressed by an enabled write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seg_q[g] <= '0;
            end else if (we && (wsel == 2'(g))) begin
                seg_q[g] <= wdata;
            end
        end
    end

    // Read mux driven by the request selector.
    always_comb begin
        rdata = seg_q[rsel];
    end

    AST_SEG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (seg_q[$past(wsel)] == $past(wdata))) // R6
        else $error("segment write did not land");
endmodule

// File: rtl/seg_lin_adder.sv
// Module: seg_lin_adder
// Shifts the segment left by SHIFT and adds the offset, keeping the carry bit.
// Assumes: SEG_W + SHIFT >= OFF_W; the result is purely combinational.
module seg_lin_adder #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int BASE_W = ((SEG_W + SHIFT) > OFF_W) ? (SEG_W + SHIFT) : OFF_W,
    localparam int SUM_W  = BASE_W + 1
) (
    input  logic [SEG_W-1:0] seg_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [SUM_W-1:0] sum_o
);
    logic [SUM_W-1:0] base_ext;
    logic [SUM_W-1:0] off_ext;

    // Widen both operands so the addition cannot drop a carry.
    always_comb begin
        base_ext = SUM_W'(seg_i) << SHIFT;
        off_ext  = SUM_W'(off_i);
        sum_o    = base_ext + off_ext;
    end
endmodule

// File: rtl/seg_a20_gate.sv
// Module: seg_a20_gate
// Holds the gate control flag and masks the top address bit with it.
// Assumes: reset closes the gate; a gate write is seen from the next cycle on.
module seg_a20_gate #(
    parameter int SUM_W = 21,
    localparam int TOP = SUM_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_we,
    input  logic             gate_val,
    input  logic [SUM_W-1:0] sum_i,
    output logic [SUM_W-1:0] addr_o,
    output logic             carry_o,
    output logic             gate_open_o
);
    logic gate_q;

    // Gate control register, closed after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else if (gate_we) begin
            gate_q <= gate_val;
        end
    end

    // Pass or clear the top bit; report the raw carry.
    always_comb begin
        addr_o      = {sum_i[TOP] & gate_q, sum_i[TOP-1:0]};
        carry_o     = sum_i[TOP];
        gate_open_o = gate_q;
    end

    AST_GATE_RESET: assert property (@(posedge clk)
        $past(!rst_n) |-> !gate_q) // R3
        else $error("gate not closed after reset");
endmodule

// File: rtl/seg_addr_gen.sv
// Module: seg_addr_gen (top)
// Segmented address generator: register file, shift-add, gate, output register.
// Assumes: one request per cycle at most; results are registered, latency one.
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = SEG_W_DEF,
    parameter int OFF_W = OFF_W_DEF,
    parameter int SHIFT = SHIFT_DEF,
    localparam int BASE_W = ((SEG_W + SHIFT) > OFF_W) ? (SEG_W + SHIFT) : OFF_W,
    localparam int SUM_W  = BASE_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seg_we,
    input  logic [1:0]       seg_wsel,
    input  logic [SEG_W-1:0] seg_wdata,
    input  logic             gate_we,
    input  logic             gate_open_in,
    input  logic             req,
    input  logic [1:0]       req_sel,
    input  logic [OFF_W-1:0] req_off,
    output logic [SUM_W-1:0] phys_addr,
    output logic             addr_valid,
    output logic             carry_ovf
);
    logic [SEG_W-1:0] seg_val;
    logic [SUM_W-1:0] raw_sum;
    logic [SUM_W-1:0] gated_addr;
    logic             raw_carry;
    logic             gate_open;

    seg_regfile #(.SEG_W(SEG_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (seg_we),
        .wsel  (seg_wsel),
        .wdata (seg_wdata),
        .rsel  (req_sel),
        .rdata (seg_val)
    );

    seg_lin_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_add (
        .seg_i (seg_val),
        .off_i (req_off),
        .sum_o (raw_sum)
    );

    seg_a20_gate #(.SUM_W(SUM_W)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .gate_we     (gate_we),
        .gate_val    (gate_open_in),
        .sum_i       (raw_sum),
        .addr_o      (gated_addr),
        .carry_o     (raw_carry),
        .gate_open_o (gate_open)
    );

    // Capture the result on a request; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys_addr  <= '0;
            carry_ovf  <= 1'b0;
            addr_valid <= 1'b0;
        end else begin
            addr_valid <= req;
            if (req) begin
                phys_addr <= gated_addr;
                carry_ovf <= raw_carry;
            end
        end
    end

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> addr_valid) // R7
        else $error("valid missing after request");

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !addr_valid) // R7
        else $error("valid without request");

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> ($stable(phys_addr) && $stable(carry_ovf))) // R7
        else $error("outputs changed without request");

    AST_MASKED_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !gate_open) |=> !phys_addr[SUM_W-1]) // R2
        else $error("top bit set while gate closed");

    AST_TOP_IMPLIES_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[SUM_W-1] |-> carry_ovf) // R4
        else $error("top bit without overflow flag");
endmodule

// File: tb/seg_addr_gen_tb.sv
// Bench for seg_addr_gen: vector table, then directed reset and corner tests.
module seg_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_we = 1'b0;
    logic [1:0]  seg_wsel = 2'b00;
    logic [15:0] seg_wdata = '0;
    logic        gate_we = 1'b0;
    logic        gate_open_in = 1'b0;
    logic        req = 1'b0;
    logic [1:0]  req_sel = 2'b00;
    logic [15:0] req_off = '0;
    logic [20:0] phys_addr;
    logic        addr_valid;
    logic        carry_ovf;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    seg_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_wsel(seg_wsel),
        .seg_wdata(seg_wdata), .gate_we(gate_we), .gate_open_in(gate_open_in),
        .req(req), .req_sel(req_sel), .req_off(req_off),
        .phys_addr(phys_addr), .addr_valid(addr_valid), .carry_ovf(carry_ovf)
    );

    // gate, sel, segment, offset, expected address, expected overflow
    localparam logic [56:0] VEC [8] = '{
        {1'b1, 2'd1, 16'h1234, 16'h0010, 21'h012350, 1'b0},
        {1'b1, 2'd3, 16'hFFFF, 16'h0010, 21'h100000, 1'b1},
        {1'b0, 2'd3, 16'hFFFF, 16'h0010, 21'h000000, 1'b1},
        {1'b0, 2'd2, 16'hFFFF, 16'hFFFF, 21'h00FFEF, 1'b1},
        {1'b1, 2'd2, 16'hFFFF, 16'hFFFF, 21'h10FFEF, 1'b1},
        {1'b1, 2'd0, 16'h0000, 16'hFFFF, 21'h00FFFF, 1'b0},
        {1'b0, 2'd0, 16'hF000, 16'hFFFF, 21'h0FFFFF, 1'b0},
        {1'b1, 2'd1, 16'h0001, 16'h0000, 21'h000010, 1'b0}
    };

    task automatic check(input bit ok, input string rq, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic wr_seg(input logic [1:0] s, input logic [15:0] v);
        @(negedge clk);
        seg_we = 1'b1; seg_wsel = s; seg_wdata = v;
        @(negedge clk);
        seg_we = 1'b0;
    endtask

    task automatic wr_gate(input logic v);
        @(negedge clk);
        gate_we = 1'b1; gate_open_in = v;
        @(negedge clk);
        gate_we = 1'b0;
    endtask

    // Issue one request; results are sampled on the following negedge.
    task automatic do_req(input logic [1:0] s, input logic [15:0] o);
        @(negedge clk);
        req = 1'b1; req_sel = s; req_off = o;
        @(negedge clk);
        req = 1'b0;
    endtask

    initial begin : watchdog
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R8: reset state
        check(phys_addr == 21'h0 && !addr_valid && !carry_ovf, "R8 reset outputs",
              {carry_ovf, addr_valid, phys_addr}, 0);
        rst_n = 1'b1;

        // R3: gate closed after reset, so FFFF:0010 wraps to zero
        wr_seg(2'd1, 16'hFFFF);
        do_req(2'd1, 16'h0010);
        check(phys_addr == 21'h0, "R3 closed gate after reset", phys_addr, 0);
        check(carry_ovf == 1'b1, "R4 overflow with gate closed", carry_ovf, 1);
        check(addr_valid == 1'b1, "R7 valid after request", addr_valid, 1);
        @(negedge clk);
        check(addr_valid == 1'b0, "R7 valid drops without request", addr_valid, 0);
        check(phys_addr == 21'h0 && carry_ovf, "R7 outputs held", phys_addr, 0);

        // Table walk: R1 R2 R4 across gate settings and registers
        for (int i = 0; i < 8; i++) begin
            wr_gate(VEC[i][56]);
            wr_seg(VEC[i][55:54], VEC[i][53:38]);
            do_req(VEC[i][55:54], VEC[i][37:22]);
            check(phys_addr == VEC[i][21:1],
                  VEC[i][56] ? "R1 open-gate address" : "R2 closed-gate wrap",
                  phys_addr, VEC[i][21:1]);
            check(carry_ovf == VEC[i][0], "R4 overflow flag", carry_ovf, VEC[i][0]);
        end

        // R5: four independent registers with the stated encoding
        wr_seg(2'd0, 16'h0100);
        wr_seg(2'd1, 16'h0200);
        wr_seg(2'd2, 16'h0300);
        wr_seg(2'd3, 16'h0400);
        for (int s = 0; s < 4; s++) begin
            do_req(2'(s), 16'h0000);
            check(phys_addr == 21'(32'h1000 * (s + 1)), "R5 register select",
                  phys_addr, 32'h1000 * (s + 1));
        end

        // R6: write data ignored while write enable is low
        @(negedge clk);
        seg_we = 1'b0; seg_wsel = 2'd3; seg_wdata = 16'hABCD;
        @(negedge clk);
        do_req(2'd3, 16'h0000);
        check(phys_addr == 21'h004000, "R6 no write without enable", phys_addr, 21'h004000);

        // R6: request in the write cycle reads the old value, then the new one
        @(negedge clk);
        seg_we = 1'b1; seg_wsel = 2'd1; seg_wdata = 16'h2222;
        req = 1'b1; req_sel = 2'd1; req_off = 16'h0000;
        @(negedge clk);
        seg_we = 1'b0; req = 1'b0;
        check(phys_addr == 21'h002000, "R6 old value in write cycle", phys_addr, 21'h002000);
        do_req(2'd1, 16'h0000);
        check(phys_addr == 21'h022220, "R6 new value after write", phys_addr, 21'h022220);

        // R9: gate change shares a cycle with a request
        wr_gate(1'b0);
        wr_seg(2'd3, 16'hFFFF);
        @(negedge clk);
        gate_we = 1'b1; gate_open_in = 1'b1;
        req = 1'b1; req_sel = 2'd3; req_off = 16'h0020;
        @(negedge clk);
        gate_we = 1'b0; req = 1'b0;
        check(phys_addr == 21'h000010, "R9 old gate in same cycle", phys_addr, 21'h000010);
        do_req(2'd3, 16'h0020);
        check(phys_addr == 21'h100010, "R9 new gate next cycle", phys_addr, 21'h100010);

        // R8: reset clears registers and outputs again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(phys_addr == 21'h0 && !addr_valid && !carry_ovf, "R8 outputs in reset",
              {carry_ovf, addr_valid, phys_addr}, 0);
        rst_n = 1'b1;
        wr_gate(1'b1);
        do_req(2'd3, 16'h0005);
        check(phys_addr == 21'h000005, "R8 register cleared by reset", phys_addr, 21'h5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule